// File: doc/BRIEF.md
# Token-Passing Shift-Chain Network Node

This block is one stage of an open word chain that threads many compute nodes between a host that writes at one end and a host that reads at the other. Each stage holds one typed word. A word moves forward one stage only when the next stage can take it, so gaps close up toward the read end and the chain itself serves as the queue. The permission to move travels backward: a stage tells its upstream neighbour it can accept a word when its own slot is empty or is being emptied this cycle.

The node watches the words it accepts for a two-word load packet addressed to its own fixed position. When it sees one, it hands the loaded value to a local compute job with a one-cycle start pulse. When the job reports completion, the node keeps the final value and the cycle count until a token word arrives from upstream. It then takes the token out of the stream, stops accepting from upstream, places a four-word result packet into its slot one word per free slot, and then puts the token back so that nodes further down can send in turn.

Top module: `chain_node`

## Requirements
- R1: After reset the slot holds an empty word (kind 0 on `dn_kind`), `up_rdy` is high and `job_start` is low.
- R2: Word kinds are coded empty=0, load-address=1, load-value=2, token=3, result-address=4, result-value=5, result-count-low=6, result-count-high=7. A word accepted from upstream appears unchanged on `dn_kind`/`dn_data` in the next cycle, and an occupied slot keeps its word while `dn_rdy` is low.
- R3: In the same cycle, `up_rdy` is high exactly when no token is held and the slot is either empty or `dn_rdy` is high; a non-empty upstream word is accepted only when `up_rdy` is high.
- R4: An accepted load-address word whose data equals `NODE_ID`, followed by an accepted load-value word as the next accepted non-empty word, raises `job_start` for one cycle in the cycle after the value word is accepted, with `job_x0` equal to that value. Any other address, or any other word in between, starts nothing.
- R5: A token arriving while no result is pending passes through like any other word.
- R6: A token arriving while a result is pending is withheld. The node then fills its next four free slots with result-address (`NODE_ID`), result-value (final X), result-count-low (count bits W-1..0) and result-count-high (count bits 2W-1..W), in that order. The token, with its data unchanged, fills the fifth free slot, and this clears the pending result.
- R7: From token capture until the token is released, `up_rdy` stays low, so no upstream word is accepted or decoded.
- R8: A `job_done` pulse while a result is already pending is ignored. The stored result is the one from the first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_kind | input | 3 | Kind of the word offered by the upstream stage |
| up_data | input | W | Data of the word offered by the upstream stage |
| up_rdy | output | 1 | This node accepts the offered word this cycle |
| dn_kind | output | 3 | Kind of the word held in this node's slot |
| dn_data | output | W | Data of the word held in this node's slot |
| dn_rdy | input | 1 | Downstream stage takes the slot's word this cycle |
| job_start | output | 1 | One-cycle pulse that starts the local job |
| job_x0 | output | W | Initial X for the local job |
| job_done | input | 1 | Local job finished (one-cycle pulse) |
| job_x | input | W | Final X of the local job |
| job_cycles | input | 2W | Cycle count of the local job |

## Verification
The assertions check on every cycle that a blocked slot keeps its word, that a token passes straight through when nothing is pending, that a held token always returns into the slot at release, that a held token implies a pending result, that no load starts while a token is held, and that a pending result stays frozen against later completion pulses. Only the bench scenarios can show the order and content of the result packet in the stream, the rejection of foreign or interrupted load packets, and the exact cycle-by-cycle interplay between backward readiness and forward movement under changing downstream stalls.

// File: rtl/chain_node_pkg.sv
package chain_node_pkg;

   typedef enum logic [2:0] {
      K_EMPTY = 3'd0,
      K_ADDR  = 3'd1,
      K_VALUE = 3'd2,
      K_TOKEN = 3'd3,
      K_RADDR = 3'd4,
      K_RX    = 3'd5,
      K_RLO   = 3'd6,
      K_RHI   = 3'd7
   } kind_e;

   localparam int unsigned KIND_W    = 3;
   localparam int unsigned CNT_WORDS = 2;
   localparam int unsigned RES_WORDS = 2 + CNT_WORDS;

endpackage

// File: rtl/cn_load_decode.sv
module cn_load_decode
   import chain_node_pkg::*;
#(
   parameter int unsigned W       = 16,
   parameter int unsigned NODE_ID = 5
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                accept,
   input  logic [KIND_W-1:0]   kind,
   input  logic [W-1:0]        data,
   output logic                job_start,
   output logic [W-1:0]        job_x0
);

   localparam logic [W-1:0] MY_ADDR = W'(NODE_ID);

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         job_start <= 1'b0;
         job_x0    <= '0;
      end else begin
         job_start <= 1'b0;
         if (accept) begin
            case (kind)
               K_ADDR:  armed <= (data == MY_ADDR);
               K_VALUE: begin
                  if (armed) begin
                     job_start <= 1'b1;
                     job_x0    <= data;
                  end
                  armed <= 1'b0;
               end
               default: armed <= 1'b0;
            endcase
         end
      end
   end

   // a start needs two accepted words, so pulses never touch
   assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      job_start |=> !job_start);

endmodule

// File: rtl/cn_result_seq.sv
module cn_result_seq
   import chain_node_pkg::*;
#(
   parameter int unsigned W       = 16,
   parameter int unsigned NODE_ID = 5
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                job_done,
   input  logic [W-1:0]        job_x,
   input  logic [2*W-1:0]      job_cycles,
   input  logic                tok_capture,
   input  logic [W-1:0]        tok_data,
   input  logic                slot_free,
   output logic                pending,
   output logic                token_held,
   output logic                ins_valid,
   output logic [KIND_W-1:0]   ins_kind,
   output logic [W-1:0]        ins_data
);

   localparam int unsigned IDX_W = $clog2(RES_WORDS + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RES_WORDS);

   logic [W-1:0]        res_x;
   logic [2*W-1:0]      res_cnt;
   logic [W-1:0]        held_tok;
   logic [IDX_W-1:0]    idx;
   logic [W-1:0]        cnt_word [CNT_WORDS];
   logic                release_now;

   for (genvar g = 0; g < CNT_WORDS; g++) begin : g_cnt_split
      assign cnt_word[g] = res_cnt[g*W +: W];
   end

   assign ins_valid   = token_held && slot_free;
   assign release_now = ins_valid && (idx == LAST_IDX);

   always_comb begin
      ins_kind = K_TOKEN;
      ins_data = held_tok;
      case (idx)
         IDX_W'(0): begin ins_kind = K_RADDR; ins_data = W'(NODE_ID); end
         IDX_W'(1): begin ins_kind = K_RX;    ins_data = res_x;       end
         IDX_W'(2): begin ins_kind = K_RLO;   ins_data = cnt_word[0]; end
         IDX_W'(3): begin ins_kind = K_RHI;   ins_data = cnt_word[1]; end
         default:   begin ins_kind = K_TOKEN; ins_data = held_tok;    end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending    <= 1'b0;
         token_held <= 1'b0;
         idx        <= '0;
         res_x      <= '0;
         res_cnt    <= '0;
         held_tok   <= '0;
      end else begin
         if (job_done && !pending) begin
            pending <= 1'b1;
            res_x   <= job_x;
            res_cnt <= job_cycles;
         end
         if (tok_capture) begin
            token_held <= 1'b1;
            held_tok   <= tok_data;
            idx        <= '0;
         end else if (ins_valid) begin
            if (release_now) begin
               token_held <= 1'b0;
               pending    <= 1'b0;
               idx        <= '0;
            end else begin
               idx <= idx + IDX_W'(1);
            end
         end
      end
   end

   // a held token always belongs to a pending result
   assert_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
      token_held |-> pending);

   // later completion pulses leave a pending result untouched
   assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !release_now) |=> (pending && $stable(res_x) && $stable(res_cnt)));

endmodule

// File: rtl/chain_node.sv
module chain_node
   import chain_node_pkg::*;
#(
   parameter int unsigned W       = 16,
   parameter int unsigned NODE_ID = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        up_kind,
   input  logic [W-1:0]      up_data,
   output logic              up_rdy,
   output logic [2:0]        dn_kind,
   output logic [W-1:0]      dn_data,
   input  logic              dn_rdy,
   output logic              job_start,
   output logic [W-1:0]      job_x0,
   input  logic              job_done,
   input  logic [W-1:0]      job_x,
   input  logic [2*W-1:0]    job_cycles
);

   if (W < 4 || W > 32) begin : g_bad_width
      $error("chain_node: W must lie in 4..32");
   end
   if ((64'(NODE_ID) >> W) != 64'd0) begin : g_bad_id
      $error("chain_node: NODE_ID does not fit in W bits");
   end

   logic [KIND_W-1:0] slot_kind;
   logic [W-1:0]      slot_data;
   logic              slot_free, accept, tok_capture;
   logic              pending, token_held, ins_valid;
   logic [KIND_W-1:0] ins_kind;
   logic [W-1:0]      ins_data;

   assign slot_free   = (slot_kind == K_EMPTY) || dn_rdy;
   assign up_rdy      = slot_free && !token_held;
   assign accept      = up_rdy && (up_kind != K_EMPTY);
   assign tok_capture = accept && (up_kind == K_TOKEN) && pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_kind <= K_EMPTY;
         slot_data <= '0;
      end else if (ins_valid) begin
         slot_kind <= ins_kind;
         slot_data <= ins_data;
      end else if (slot_free) begin
         if (accept && !tok_capture) begin
            slot_kind <= up_kind;
            slot_data <= up_data;
         end else begin
            slot_kind <= K_EMPTY;
            slot_data <= '0;
         end
      end
   end

   assign dn_kind = slot_kind;
   assign dn_data = slot_data;

   cn_load_decode #(.W(W), .NODE_ID(NODE_ID)) i_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .kind      (up_kind),
      .data      (up_data),
      .job_start (job_start),
      .job_x0    (job_x0)
   );

   cn_result_seq #(.W(W), .NODE_ID(NODE_ID)) i_result (
      .clk         (clk),
      .rst_n       (rst_n),
      .job_done    (job_done),
      .job_x       (job_x),
      .job_cycles  (job_cycles),
      .tok_capture (tok_capture),
      .tok_data    (up_data),
      .slot_free   (slot_free),
      .pending     (pending),
      .token_held  (token_held),
      .ins_valid   (ins_valid),
      .ins_kind    (ins_kind),
      .ins_data    (ins_data)
   );

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_kind != K_EMPTY && !dn_rdy) |=> ($stable(slot_kind) && $stable(slot_data)));

   assert_token_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && up_kind == K_TOKEN && !pending) |=> (slot_kind == K_TOKEN));

   assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(token_held) |-> (slot_kind == K_TOKEN));

   assert_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      token_held |-> !job_start);

endmodule

// File: tb/test_chain_node.sv
module test_chain_node;

   localparam int W  = 16;
   localparam int ID = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        up_kind = '0;
   logic [W-1:0]      up_data = '0;
   logic              up_rdy;
   logic [2:0]        dn_kind;
   logic [W-1:0]      dn_data;
   logic              dn_rdy = 1'b0;
   logic              job_start;
   logic [W-1:0]      job_x0;
   logic              job_done = 1'b0;
   logic [W-1:0]      job_x = '0;
   logic [2*W-1:0]    job_cycles = '0;

   always #5 clk = ~clk;

   chain_node #(.W(W), .NODE_ID(ID)) i_chain_node (.*);

   int n_vec = 0, n_err = 0;
   int rmode = 0;
   logic [15:0] lfsr = 16'hACE1;
   int cyc = 0;

   // source and sink
   int src_k[$], src_d[$];
   int sk_k[$], sk_d[$];
   int n_start = 0;

   // job completion request
   bit done_req = 0;
   logic [W-1:0]   done_x = '0;
   logic [2*W-1:0] done_c = '0;

   // reference model state
   int m_k = 0, m_d = 0;
   bit m_tok = 0, m_pend = 0, m_arm = 0, m_start = 0;
   int m_x0 = 0, m_rx = 0;
   logic [2*W-1:0] m_rc = '0;
   int mq_k[$], mq_d[$];

   task automatic check(string tag, longint act, longint exp);
      n_vec++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
      end
   endtask

   always @(posedge clk) begin
      bit free, rdy, acc, cap, o_pend;
      if (!rst_n) begin
         m_k = 0; m_d = 0; m_tok = 0; m_pend = 0; m_arm = 0;
         m_start = 0; m_x0 = 0; m_rx = 0; m_rc = '0;
         mq_k.delete(); mq_d.delete();
      end else begin
         free   = (m_k == 0) || dn_rdy;
         rdy    = free && !m_tok;
         acc    = rdy && (up_kind != 0);
         cap    = acc && (up_kind == 3) && m_pend;
         o_pend = m_pend;
         m_start = 0;
         if (acc) begin
            if (up_kind == 2 && m_arm) begin m_start = 1; m_x0 = int'(up_data); end
            m_arm = (up_kind == 1) && (int'(up_data) == ID);
         end
         if (m_tok && free) begin
            m_k = mq_k.pop_front(); m_d = mq_d.pop_front();
            if (mq_k.size() == 0) begin m_tok = 0; m_pend = 0; end
         end else if (free) begin
            if (acc && !cap) begin m_k = int'(up_kind); m_d = int'(up_data); end
            else begin m_k = 0; m_d = 0; end
         end
         if (cap) begin
            m_tok = 1;
            mq_k.push_back(4); mq_d.push_back(ID);
            mq_k.push_back(5); mq_d.push_back(m_rx);
            mq_k.push_back(6); mq_d.push_back(int'(m_rc[W-1:0]));
            mq_k.push_back(7); mq_d.push_back(int'(m_rc[2*W-1:W]));
            mq_k.push_back(3); mq_d.push_back(int'(up_data));
         end
         if (job_done && !o_pend) begin
            m_pend = 1; m_rx = int'(job_x); m_rc = job_cycles;
         end
         if (acc && src_k.size() != 0) begin
            void'(src_k.pop_front()); void'(src_d.pop_front());
         end
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cyc++;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (rmode)
            0: dn_rdy = 1'b1;
            1: dn_rdy = 1'b0;
            2: dn_rdy = cyc[0];
            default: dn_rdy = lfsr[3] | lfsr[7];
         endcase
         if (src_k.size() != 0) begin
            up_kind = 3'(src_k[0]); up_data = W'(src_d[0]);
         end else begin
            up_kind = '0; up_data = '0;
         end
         job_done = done_req;
         if (done_req) begin job_x = done_x; job_cycles = done_c; done_req = 0; end
         #1;
         check((m_tok || mq_k.size() != 0) ? "R6 slot kind" : "R2 slot kind", dn_kind, m_k);
         check((m_tok || mq_k.size() != 0) ? "R6 slot data" : "R2 slot data", dn_data, m_d);
         check(m_tok ? "R7 up_rdy" : "R3 up_rdy", up_rdy,
               ((m_k == 0 || dn_rdy) && !m_tok) ? 1 : 0);
         check("R4 job_start", job_start, m_start);
         check("R4 job_x0", job_x0, m_x0);
         if (job_start) n_start++;
         if (dn_rdy && dn_kind != 0) begin sk_k.push_back(int'(dn_kind)); sk_d.push_back(int'(dn_data)); end
      end
   endtask

   task automatic push(int k, int d);
      src_k.push_back(k); src_d.push_back(d);
   endtask

   initial begin
      int nres, ntok;
      // reset
      rmode = 1;
      step(3);
      rst_n = 1'b1;
      step(1);
      check("R1 reset slot empty", dn_kind, 0);
      check("R1 reset up_rdy", up_rdy, 1);
      check("R1 reset job_start", job_start, 0);

      // load packets, one foreign and one matching
      rmode = 0;
      push(1, 3); push(2, 16'h1111);
      push(1, ID); push(2, 16'hBEEF);
      step(8);
      check("R4 start count", n_start, 1);
      check("R4 loaded value", job_x0, 16'hBEEF);

      // stall: word must sit in the slot
      rmode = 1;
      push(2, 16'h0C0C); push(2, 16'h0D0D);
      step(5);
      check("R2 held word kind", dn_kind, 2);
      check("R2 held word data", dn_data, 16'h0C0C);
      rmode = 2;
      step(8);

      // interrupted load and a token with nothing pending
      sk_k.delete(); sk_d.delete();
      rmode = 0;
      push(1, ID); push(3, 16'h00AA); push(2, 16'h2222);
      step(8);
      check("R4 interrupted load starts nothing", n_start, 1);
      nres = 0; ntok = 0;
      foreach (sk_k[i]) begin
         if (sk_k[i] >= 4) nres++;
         if (sk_k[i] == 3) ntok++;
      end
      check("R5 no result words", nres, 0);
      check("R5 token forwarded", ntok, 1);

      // result with a second ignored completion
      done_x = 16'hABCD; done_c = 32'h1234_5678; done_req = 1;
      step(2);
      done_x = 16'h9999; done_c = 32'h0; done_req = 1;
      step(2);
      sk_k.delete(); sk_d.delete();
      rmode = 2;
      push(3, 16'h0055); push(1, ID); push(2, 16'h7777);
      step(30);
      check("R6 packet length", sk_k.size(), 7);
      if (sk_k.size() >= 7) begin
         check("R6 word0 kind", sk_k[0], 4); check("R6 word0 addr", sk_d[0], ID);
         check("R6 word1 kind", sk_k[1], 5); check("R8 result value", sk_d[1], 16'hABCD);
         check("R6 word2 kind", sk_k[2], 6); check("R8 count low", sk_d[2], 16'h5678);
         check("R6 word3 kind", sk_k[3], 7); check("R8 count high", sk_d[3], 16'h1234);
         check("R6 token back", sk_k[4], 3); check("R6 token data", sk_d[4], 16'h0055);
      end
      check("R7 load after release", n_start, 2);
      check("R7 loaded value", job_x0, 16'h7777);

      // mixed traffic with random downstream stalls
      rmode = 3;
      for (int i = 0; i < 300; i++) begin
         int k;
         k = (i % 11 == 0) ? 3 : (i % 7 == 0) ? 1 : int'(lfsr[2:0]);
         push(k, (k == 1 && i % 2 == 0) ? ID : int'(lfsr ^ 16'(i)));
         if (i % 40 == 5) begin done_x = W'(i * 77); done_c = {16'(i), lfsr}; done_req = 1; end
         step(1);
      end
      step(400);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

   initial begin
      #2000000;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

endmodule